// File: doc/BRIEF.md
# Pending Interrupt Source Resolver

This block picks the next interrupt a handler should service from three status words of a banked interrupt controller. The first is a summary word: eight basic sources of bank 0, two cascade flags that point at the full pending words of banks 1 and 2, and eleven shortcut bits that stand for frequently used bank 1 and bank 2 sources. The other two inputs are the full 32-bit pending words of banks 1 and 2.

The resolver masks the summary word to its meaningful bits and applies a fixed group order. Shortcut positions are translated back to their true bank and source numbers, and a cascade hit is resolved to the lowest set bit of that bank's pending word. The result is one 7-bit identifier of the form `bank * 32 + source`, plus a valid flag. The output is registered by default, so a result appears one cycle after its inputs and follows them every cycle. Software-visible storage, masking of sources and bus access belong to the surrounding controller.

Top module: `irq_pend_resolver`

## Requirements
- R1: The identifier is 7 bits wide, with the bank number in bits 6:5 and the source number within the bank in bits 4:0. A valid identifier never has bits 6:5 equal to 3.
- R2: Summary bits 21 to 31 have no effect on the output.
- R3: When no summary bit from 0 to 20 is set, the output is all ones (7'h7F) and valid is 0.
- R4: If any of summary bits 0 to 7 is set, the lowest set one wins, and the identifier equals that bit number (bank 0).
- R5: Summary bits 10, 11, 12, 13 and 14 stand for bank 1 sources 7, 9, 10, 18 and 19, which gives identifiers 39, 41, 42, 50 and 51.
- R6: Summary bits 15, 16, 17, 18, 19 and 20 stand for bank 2 sources 21, 22, 23, 24, 25 and 30, which gives identifiers 85, 86, 87, 88, 89 and 94.
- R7: The groups are ordered basic sources (0 to 7) first, then bank 1 shortcuts, then bank 2 shortcuts, then the bank 1 cascade (bit 8), then the bank 2 cascade (bit 9). Within a group, the lowest set bit wins.
- R8: A selected cascade reports the lowest set bit of that bank's pending word, with the bank number 1 or 2.
- R9: If the selected cascade flag is set while its bank's pending word is zero, the output is 7'h7F with valid 0. This holds even when a lower-priority cascade could resolve.
- R10: The output has exactly one cycle of latency and is updated on every clock. While reset is asserted, the output is 7'h7F with valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| summary_i | input | 32 | Bank 0 summary status word |
| pend1_i | input | 32 | Bank 1 full pending word |
| pend2_i | input | 32 | Bank 2 full pending word |
| id_o | output | 7 | Encoded identifier, or all ones when there is none |
| valid_o | output | 1 | Identifier is valid |

## Verification
Each shortcut bit is applied alone, which separates a correct translation table from one that is shifted or has its bank boundary in the wrong place. Pairs of bits that straddle two groups are applied together to show that the group order wins over raw bit position, since a flat encoder would choose the cascade bits before the shortcuts. Cascade flags are tried with pending words whose lowest set bit is at the bottom, in the middle and at the top, and also with an empty pending word, which checks the no-interrupt fallback. Inputs that change back to back and bits set only above position 20 show the one-cycle latency and the masking.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int SUM_W     = 32;
  localparam int PEND_W    = 32;
  localparam int SRC_W     = 5;
  localparam int BANK_W    = 2;
  localparam int ID_W      = BANK_W + SRC_W;
  localparam int NUM_BASIC = 8;
  localparam int CASC1_BIT = 8;
  localparam int CASC2_BIT = 9;
  localparam int SC_LO     = 10;
  localparam int SC1_N     = 5;
  localparam int SC2_N     = 6;
  localparam int SC_N      = SC1_N + SC2_N;
  localparam int VALID_W   = SC_LO + SC_N;
  localparam int SC_IDX_W  = $clog2(SC_N);
  localparam logic [SUM_W-1:0] VALID_MASK = SUM_W'((64'd1 << VALID_W) - 64'd1);

  typedef enum logic [2:0] {
    GRP_NONE, GRP_BASIC, GRP_SC, GRP_CASC1, GRP_CASC2
  } grp_e;

  // shortcut slot -> real source number in its bank
  function automatic logic [SRC_W-1:0] sc_src(input logic [SC_IDX_W-1:0] idx);
    case (idx)
      4'd0:    sc_src = 5'd7;
      4'd1:    sc_src = 5'd9;
      4'd2:    sc_src = 5'd10;
      4'd3:    sc_src = 5'd18;
      4'd4:    sc_src = 5'd19;
      4'd5:    sc_src = 5'd21;
      4'd6:    sc_src = 5'd22;
      4'd7:    sc_src = 5'd23;
      4'd8:    sc_src = 5'd24;
      4'd9:    sc_src = 5'd25;
      4'd10:   sc_src = 5'd30;
      default: sc_src = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_lsb_find.sv
module irq_lsb_find #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_sc_xlate.sv
module irq_sc_xlate
  import irq_res_pkg::*;
(
  input  logic [SC_N-1:0]   sc_i,
  output logic              any_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [SRC_W-1:0]  src_o
);
  logic [SC_IDX_W-1:0] idx;

  // bank 1 slots sit below bank 2 slots, so lowest slot also honours bank order
  irq_lsb_find #(.W(SC_N), .IDX_W(SC_IDX_W)) u_find (
    .vec_i (sc_i),
    .any_o (any_o),
    .idx_o (idx)
  );

  assign bank_o = (int'(idx) < SC1_N) ? BANK_W'(1) : BANK_W'(2);
  assign src_o  = sc_src(idx);
endmodule

// File: rtl/irq_res_core.sv
module irq_res_core
  import irq_res_pkg::*;
(
  input  logic [SUM_W-1:0]  summary_i,
  input  logic [PEND_W-1:0] pend1_i,
  input  logic [PEND_W-1:0] pend2_i,
  output logic [ID_W-1:0]   id_o,
  output logic              valid_o
);
  localparam int BASIC_IDX_W = $clog2(NUM_BASIC);
  localparam int PEND_IDX_W  = $clog2(PEND_W);

  logic [SUM_W-1:0]       masked;
  logic                   basic_any, sc_any, p1_any, p2_any;
  logic [BASIC_IDX_W-1:0] basic_idx;
  logic [PEND_IDX_W-1:0]  p1_idx, p2_idx;
  logic [BANK_W-1:0]      sc_bank, bank;
  logic [SRC_W-1:0]       sc_src_n, src;
  grp_e                   grp;
  logic                   hit;

  assign masked = summary_i & VALID_MASK;

  irq_lsb_find #(.W(NUM_BASIC), .IDX_W(BASIC_IDX_W)) u_basic (
    .vec_i (masked[NUM_BASIC-1:0]),
    .any_o (basic_any),
    .idx_o (basic_idx)
  );

  irq_sc_xlate u_sc (
    .sc_i   (masked[SC_LO+SC_N-1:SC_LO]),
    .any_o  (sc_any),
    .bank_o (sc_bank),
    .src_o  (sc_src_n)
  );

  irq_lsb_find #(.W(PEND_W), .IDX_W(PEND_IDX_W)) u_p1 (
    .vec_i (pend1_i),
    .any_o (p1_any),
    .idx_o (p1_idx)
  );

  irq_lsb_find #(.W(PEND_W), .IDX_W(PEND_IDX_W)) u_p2 (
    .vec_i (pend2_i),
    .any_o (p2_any),
    .idx_o (p2_idx)
  );

  always_comb begin
    if (basic_any)              grp = GRP_BASIC;
    else if (sc_any)            grp = GRP_SC;
    else if (masked[CASC1_BIT]) grp = GRP_CASC1;
    else if (masked[CASC2_BIT]) grp = GRP_CASC2;
    else                        grp = GRP_NONE;
  end

  always_comb begin
    bank = '0;
    src  = '0;
    hit  = 1'b0;
    unique case (grp)
      GRP_BASIC: begin bank = '0;        src = SRC_W'(basic_idx); hit = 1'b1;   end
      GRP_SC:    begin bank = sc_bank;   src = sc_src_n;          hit = 1'b1;   end
      GRP_CASC1: begin bank = BANK_W'(1); src = SRC_W'(p1_idx);   hit = p1_any; end
      GRP_CASC2: begin bank = BANK_W'(2); src = SRC_W'(p2_idx);   hit = p2_any; end
      default:   begin bank = '0;        src = '0;                hit = 1'b0;   end
    endcase
  end

  assign valid_o = hit && (|masked);
  assign id_o    = valid_o ? {bank, src} : '1;
endmodule

// File: rtl/irq_pend_resolver.sv
module irq_pend_resolver
  import irq_res_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SUM_W-1:0]  summary_i,
  input  logic [PEND_W-1:0] pend1_i,
  input  logic [PEND_W-1:0] pend2_i,
  output logic [ID_W-1:0]   id_o,
  output logic              valid_o
);
  logic [ID_W-1:0] id_c;
  logic            valid_c;

  irq_res_core u_core (
    .summary_i (summary_i),
    .pend1_i   (pend1_i),
    .pend2_i   (pend2_i),
    .id_o      (id_c),
    .valid_o   (valid_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [ID_W-1:0] id_q;
      logic            valid_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          id_q    <= '1;
          valid_q <= 1'b0;
        end else begin
          id_q    <= id_c;
          valid_q <= valid_c;
        end
      end
      assign id_o    = id_q;
      assign valid_o = valid_q;

      a_r1_bank_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (id_o[ID_W-1:SRC_W] != '1));
      a_r3_idle_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (summary_i[VALID_W-1:0] == '0) |=> (!valid_o && id_o == '1));
      a_r4_basic_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|summary_i[NUM_BASIC-1:0]) |=> (valid_o && id_o[ID_W-1:SRC_W] == '0));
      a_r7_sc1_over_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (summary_i[NUM_BASIC-1:0] == '0 && |summary_i[SC_LO+SC1_N-1:SC_LO])
        |=> (valid_o && id_o[ID_W-1:SRC_W] == BANK_W'(1)));
      a_r9_empty_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (summary_i[VALID_W-1:0] == (VALID_W'(1) << CASC1_BIT) && pend1_i == '0)
        |=> !valid_o);
      a_r10_none_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (id_o == '1));
    end else begin : g_comb
      assign id_o    = id_c;
      assign valid_o = valid_c;
    end
  endgenerate
endmodule

// File: tb/tb_irq_pend_resolver.sv
module tb_irq_pend_resolver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] summary_i = '0;
  logic [31:0] pend1_i = '0;
  logic [31:0] pend2_i = '0;
  logic [6:0]  id_o;
  logic        valid_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_pend_resolver dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .summary_i (summary_i),
    .pend1_i   (pend1_i),
    .pend2_i   (pend2_i),
    .id_o      (id_o),
    .valid_o   (valid_o)
  );

  task automatic check(input logic [6:0] exp_id, input logic exp_v, input string req);
    n_vec++;
    if (id_o !== exp_id || valid_o !== exp_v) begin
      n_err++;
      $display("FAIL %s: id=%0d valid=%0b expected id=%0d valid=%0b",
               req, id_o, valid_o, exp_id, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [31:0] p1, input logic [31:0] p2,
                       input logic [6:0] exp_id, input logic exp_v, input string req);
    @(negedge clk_i);
    summary_i = s; pend1_i = p1; pend2_i = p2;
    @(negedge clk_i);
    check(exp_id, exp_v, req);
  endtask

  task automatic t_reset;
    check(7'h7F, 1'b0, "R10 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_idle_and_mask;
    apply(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'h7F, 1'b0, "R3 idle");
    apply(32'hFFE0_0000, 32'h1, 32'h1, 7'h7F, 1'b0, "R2 high bits ignored");
    apply(32'hFFE0_0004, 32'h0, 32'h0, 7'd2, 1'b1, "R2 high bits with basic");
  endtask

  task automatic t_basic;
    apply(32'h0000_0084, 32'h0, 32'h0, 7'd2, 1'b1, "R4 lowest basic");
    apply(32'h0000_0080, 32'h0, 32'h0, 7'd7, 1'b1, "R4 basic bit 7");
    apply(32'h001F_FFFF, 32'h1, 32'h1, 7'd0, 1'b1, "R7 basic over all");
  endtask

  task automatic t_shortcuts;
    logic [6:0] exp1 [5] = '{7'd39, 7'd41, 7'd42, 7'd50, 7'd51};
    logic [6:0] exp2 [6] = '{7'd85, 7'd86, 7'd87, 7'd88, 7'd89, 7'd94};
    for (int i = 0; i < 5; i++)
      apply(32'h1 << (10 + i), 32'h0, 32'h0, exp1[i], 1'b1, "R5 bank1 shortcut");
    for (int i = 0; i < 6; i++)
      apply(32'h1 << (15 + i), 32'h0, 32'h0, exp2[i], 1'b1, "R6 bank2 shortcut");
    apply(32'h0000_1400, 32'h0, 32'h0, 7'd39, 1'b1, "R5 lowest shortcut");
  endtask

  task automatic t_order;
    apply(32'h0000_C100, 32'h1, 32'h1, 7'd51, 1'b1, "R7 sc1 over sc2 and cascade");
    apply(32'h0000_8300, 32'h1, 32'h1, 7'd85, 1'b1, "R7 sc2 over cascades");
    apply(32'h0000_0300, 32'h0000_0100, 32'h1, 7'd40, 1'b1, "R7 cascade1 over cascade2");
  endtask

  task automatic t_cascade;
    apply(32'h0000_0100, 32'h0000_00F0, 32'h0, 7'd36, 1'b1, "R8 cascade1 mid");
    apply(32'h0000_0100, 32'h8000_0000, 32'h0, 7'd63, 1'b1, "R8 cascade1 top");
    apply(32'h0000_0200, 32'h0, 32'h8000_0000, 7'd95, 1'b1, "R8 cascade2 top");
    apply(32'h0000_0200, 32'h0, 32'h0000_0001, 7'd64, 1'b1, "R8 cascade2 bottom");
    apply(32'h0000_0100, 32'h0, 32'h1, 7'h7F, 1'b0, "R9 empty cascade1");
    apply(32'h0000_0200, 32'h1, 32'h0, 7'h7F, 1'b0, "R9 empty cascade2");
    apply(32'h0000_0300, 32'h0, 32'h1, 7'h7F, 1'b0, "R9 empty cascade1 shadows cascade2");
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    summary_i = 32'h0000_0001; pend1_i = '0; pend2_i = '0;
    @(negedge clk_i);
    summary_i = 32'h0000_0400;
    #1 check(7'd0, 1'b1, "R10 holds until edge");
    @(negedge clk_i);
    summary_i = 32'h0;
    check(7'd39, 1'b1, "R10 back-to-back update");
    @(negedge clk_i);
    check(7'h7F, 1'b0, "R10 returns to none");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_idle_and_mask();
    t_basic();
    t_shortcuts();
    t_order();
    t_cascade();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_vec++;
    n_err++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end
endmodule